// File: doc/BRIEF.md
# Prioritised Stream Request Arbiter

This block decides which of several concurrent transfer streams owns a shared bus for its next single-item transfer. Each stream watches a bank of peripheral request lines and listens to exactly one of them, chosen by a per-stream channel-select register. A stream takes part in arbitration only when it is enabled and its chosen request line is high. Among the streams that take part, the one with the highest two-bit priority wins. Equal priorities go to the lowest stream number.

The winner receives a one-hot grant that it holds for exactly one item. The bus side signals the end of that item with a single-cycle done pulse. On that pulse the grant is released, and a one-cycle acknowledge goes back to the request line that the winning stream had selected. Arbitration then runs again on the following clock edge. The data movement itself lies outside this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: Stream s is eligible only when `stream_en[s]` is high and request bit `req_lines[s*8 + sel]` is high, where `sel` is that stream's stored channel select. A request on any other channel of that stream never produces a grant.
- R2: A pulse on `sel_wr[s]` loads `sel_data[s*3 +: 3]` into stream s's channel select only when that stream is disabled and not granted. A write made at any other time is ignored, and the stream keeps routing its earlier channel.
- R3: When eligible streams have different priorities `stream_prio[s*2 +: 2]`, the highest value wins (3 is highest, 0 is lowest).
- R4: Among eligible streams of equal top priority, the lowest-numbered stream is granted.
- R5: `grant` is one-hot or zero. After reset, `grant`, `ack` and every channel select are zero. With no eligible stream and no transfer in flight, `grant` stays zero.
- R6: When `grant` is zero, the winner's grant appears on the first rising edge at which it is eligible. The grant then stays unchanged, whatever requests, enables or priorities do, until `bus_done` is sampled high.
- R7: When `bus_done` is sampled high while a grant is held, `grant` clears on that edge and `ack` is high for exactly one cycle, on bit `g*8 + sel` of the granted stream g. A `bus_done` sampled while no grant is held produces no acknowledge.
- R8: After a release, `grant` stays zero for exactly one cycle. On the next edge it is re-arbitrated among the streams that are eligible at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 64 | Peripheral requests, stream s channel c at bit s*8+c |
| stream_en | input | 8 | Per-stream enable |
| sel_wr | input | 8 | Per-stream channel-select write strobe |
| sel_data | input | 24 | Channel-select write data, 3 bits per stream |
| stream_prio | input | 16 | Priority, 2 bits per stream, 3 highest |
| bus_done | input | 1 | One-cycle pulse marking the end of the granted item |
| grant | output | 8 | One-hot bus grant, zero when idle |
| ack | output | 64 | One-cycle acknowledge to the selected request line, same layout as req_lines |

## Verification
A grant is due on the first rising edge at which the winning stream is eligible while the bus is idle. The release and the acknowledge are both due on the edge that samples `bus_done`. The next grant comes one edge after that, and a select write is latched on the edge that samples the strobe. The bench changes inputs 1 ns after a rising edge and checks the outputs 1 ns after the edge at which each result is due. It also holds inputs across extra edges wherever a result must stay unchanged or absent.

// File: rtl/dma_arb_pkg.sv
// Package: shared defaults for the stream request arbiter.
// Assumes channel count is a power of two so a select field covers it exactly.
package dma_arb_pkg;
    localparam int unsigned DEF_STREAMS  = 8;
    localparam int unsigned DEF_CHANNELS = 8;
    localparam int unsigned DEF_PRIO_W   = 2;
endpackage

// File: rtl/arb_chan_route.sv
// Module: arb_chan_route
// Holds one stream's channel-select register and routes the selected
// request line to an eligibility flag.
// Assumes: NUM_CHANNELS is a power of two; the select is locked while the
// stream is enabled or while it holds the bus grant.
module arb_chan_route #(
    parameter int unsigned NUM_CHANNELS = 8,
    localparam int unsigned SEL_W = $clog2(NUM_CHANNELS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    granted,
    input  logic                    wr,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [NUM_CHANNELS-1:0] req_vec,
    output logic [SEL_W-1:0]        sel_q,
    output logic                    eligible
);

    // Latch a new channel select only while the stream is idle and disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr && !en && !granted) begin
            sel_q <= wr_sel;
        end
    end

    // Route the chosen request line; enable gates eligibility.
    always_comb begin
        eligible = en & req_vec[sel_q];
    end

    // R2: select cannot move while enabled or granted
    a_r2_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (en || granted) |=> $stable(sel_q));

endmodule

// File: rtl/arb_prio_pick.sv
// Module: arb_prio_pick
// Combinational choice of the winning stream: highest priority value first,
// lowest index among equals.
// Assumes: the caller registers the result; output is one-hot or zero.
module arb_prio_pick #(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned PRIO_W      = 2
) (
    input  logic [NUM_STREAMS-1:0]        eligible,
    input  logic [NUM_STREAMS*PRIO_W-1:0] prio,
    output logic [NUM_STREAMS-1:0]        pick
);

    logic [PRIO_W-1:0] best_lvl;
    logic              found;
    int unsigned       best_idx;

    // Scan upward; only a strictly higher level replaces the holder, so ties keep the lower index.
    always_comb begin
        best_lvl = '0;
        found    = 1'b0;
        best_idx = 0;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            if (eligible[s] && (!found || prio[s*PRIO_W +: PRIO_W] > best_lvl)) begin
                best_lvl = prio[s*PRIO_W +: PRIO_W];
                best_idx = s;
                found    = 1'b1;
            end
        end
    end

    // Expand the winning index into a one-hot vector.
    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            pick[s] = found && (best_idx == s);
        end
    end

endmodule

// File: rtl/arb_grant_ctrl.sv
// Module: arb_grant_ctrl
// Holds the bus grant for one item and returns the acknowledge when the
// item completes.
// Assumes: bus_done is a single-cycle pulse; a new winner is taken only
// while the grant register is empty, which gives one idle cycle per release.
module arb_grant_ctrl #(
    parameter int unsigned NUM_STREAMS  = 8,
    parameter int unsigned NUM_CHANNELS = 8,
    localparam int unsigned SEL_W  = $clog2(NUM_CHANNELS),
    localparam int unsigned LINE_N = NUM_STREAMS * NUM_CHANNELS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STREAMS-1:0]       pick,
    input  logic                         bus_done,
    input  logic [NUM_STREAMS*SEL_W-1:0] sel_flat,
    output logic [NUM_STREAMS-1:0]       grant_q,
    output logic [LINE_N-1:0]            ack_q
);

    logic [LINE_N-1:0] ack_next;

    // Map the held grant onto the request line its stream had selected.
    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            for (int c = 0; c < NUM_CHANNELS; c++) begin
                ack_next[s*NUM_CHANNELS + c] = grant_q[s] &&
                    (sel_flat[s*SEL_W +: SEL_W] == SEL_W'(c));
            end
        end
    end

    // Take a winner when idle; release and acknowledge on bus_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            ack_q   <= '0;
        end else begin
            ack_q <= '0;
            if (grant_q == '0) begin
                grant_q <= pick;
            end else if (bus_done) begin
                grant_q <= '0;
                ack_q   <= ack_next;
            end
        end
    end

    // R5: never more than one stream granted
    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R6: grant held until the item completes
    a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0 && !bus_done) |=> $stable(grant_q));

    // R7: completion gives exactly one acknowledge and frees the bus
    a_r7_ack_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0 && bus_done) |=> ($countones(ack_q) == 1 && grant_q == '0));

    // R7: no acknowledge without a held grant
    a_r7_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q == '0) |=> (ack_q == '0));

    // R8: the acknowledge cycle is the idle gap
    a_r8_gap_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != '0) |-> (grant_q == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
// Module: dma_req_arbiter (top)
// Routes one request line per stream through a locked channel select,
// picks the highest-priority eligible stream (lowest index on ties) and
// grants it the shared bus for one item.
// Assumes: request lines are level signals held until acknowledged;
// bus_done is a one-cycle pulse from the bus side.
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_STREAMS  = DEF_STREAMS,
    parameter int unsigned NUM_CHANNELS = DEF_CHANNELS,
    parameter int unsigned PRIO_W       = DEF_PRIO_W,
    localparam int unsigned SEL_W  = $clog2(NUM_CHANNELS),
    localparam int unsigned LINE_N = NUM_STREAMS * NUM_CHANNELS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LINE_N-1:0]             req_lines,
    input  logic [NUM_STREAMS-1:0]        stream_en,
    input  logic [NUM_STREAMS-1:0]        sel_wr,
    input  logic [NUM_STREAMS*SEL_W-1:0]  sel_data,
    input  logic [NUM_STREAMS*PRIO_W-1:0] stream_prio,
    input  logic                          bus_done,
    output logic [NUM_STREAMS-1:0]        grant,
    output logic [LINE_N-1:0]             ack
);

    logic [NUM_STREAMS-1:0]       eligible;
    logic [NUM_STREAMS*SEL_W-1:0] sel_flat;
    logic [NUM_STREAMS-1:0]       pick;

    // One routing slice per stream.
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_route
        arb_chan_route #(
            .NUM_CHANNELS(NUM_CHANNELS)
        ) u_route (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (stream_en[s]),
            .granted (grant[s]),
            .wr      (sel_wr[s]),
            .wr_sel  (sel_data[s*SEL_W +: SEL_W]),
            .req_vec (req_lines[s*NUM_CHANNELS +: NUM_CHANNELS]),
            .sel_q   (sel_flat[s*SEL_W +: SEL_W]),
            .eligible(eligible[s])
        );
    end

    arb_prio_pick #(
        .NUM_STREAMS(NUM_STREAMS),
        .PRIO_W     (PRIO_W)
    ) u_pick (
        .eligible(eligible),
        .prio    (stream_prio),
        .pick    (pick)
    );

    arb_grant_ctrl #(
        .NUM_STREAMS (NUM_STREAMS),
        .NUM_CHANNELS(NUM_CHANNELS)
    ) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick    (pick),
        .bus_done(bus_done),
        .sel_flat(sel_flat),
        .grant_q (grant),
        .ack_q   (ack)
    );

    // R1: a fresh grant only goes to a stream that was eligible
    a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> ((grant & ~$past(eligible)) == '0));

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
    localparam int NS = 8;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [63:0]   req_lines;
    logic [7:0]    stream_en;
    logic [7:0]    sel_wr;
    logic [23:0]   sel_data;
    logic [15:0]   stream_prio;
    logic          bus_done;
    logic [7:0]    grant;
    logic [63:0]   ack;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_req_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .stream_en(stream_en),
        .sel_wr(sel_wr), .sel_data(sel_data), .stream_prio(stream_prio),
        .bus_done(bus_done), .grant(grant), .ack(ack)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_sel(input int s, input int c);
        sel_data[s*3 +: 3] = 3'(c);
        sel_wr[s] = 1'b1;
        tick();
        sel_wr[s] = 1'b0;
    endtask

    task automatic pulse_done();
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R5", "grant after reset", 64'(grant), 64'h0);
        check("R5", "ack after reset", ack, 64'h0);
        tick();
        check("R5", "idle grant", 64'(grant), 64'h0);
    endtask

    task automatic t_route();
        set_sel(2, 5);
        stream_prio[2*2 +: 2] = 2'd1;
        stream_en[2] = 1'b1;
        req_lines[2*NC + 3] = 1'b1;
        tick();
        check("R1", "unselected channel", 64'(grant), 64'h0);
        req_lines[2*NC + 5] = 1'b1;
        tick();
        check("R1", "selected channel grant", 64'(grant), 64'h04);
        pulse_done();
        check("R7", "release grant", 64'(grant), 64'h0);
        check("R7", "ack line", ack, 64'h1 << (2*NC + 5));
        tick();
        check("R7", "ack one cycle", ack, 64'h0);
        check("R8", "regrant after gap", 64'(grant), 64'h04);
        req_lines = '0;
        pulse_done();
        tick();
        check("R5", "idle after drain", 64'(grant), 64'h0);
    endtask

    task automatic t_lock();
        set_sel(2, 1);
        req_lines[2*NC + 1] = 1'b1;
        tick();
        tick();
        check("R2", "write ignored while enabled", 64'(grant), 64'h0);
        req_lines[2*NC + 5] = 1'b1;
        tick();
        check("R2", "old select still routes", 64'(grant), 64'h04);
        req_lines = '0;
        pulse_done();
        check("R2", "ack on old channel", ack, 64'h1 << (2*NC + 5));
        tick();
        stream_en[2] = 1'b0;
        set_sel(2, 1);
        stream_en[2] = 1'b1;
        req_lines[2*NC + 1] = 1'b1;
        tick();
        check("R2", "new select after disable", 64'(grant), 64'h04);
        req_lines = '0;
        pulse_done();
        check("R2", "ack on new channel", ack, 64'h1 << (2*NC + 1));
        stream_en[2] = 1'b0;
        tick();
    endtask

    task automatic t_prio();
        stream_prio[4*2 +: 2] = 2'd1;
        stream_prio[5*2 +: 2] = 2'd3;
        stream_prio[6*2 +: 2] = 2'd2;
        stream_en[6:4] = 3'b111;
        req_lines[4*NC] = 1'b1;
        req_lines[5*NC] = 1'b1;
        req_lines[6*NC] = 1'b1;
        tick();
        check("R3", "level 3 wins", 64'(grant), 64'h20);
        req_lines[5*NC] = 1'b0;
        pulse_done();
        tick();
        check("R3", "level 2 next", 64'(grant), 64'h40);
        req_lines[6*NC] = 1'b0;
        pulse_done();
        tick();
        check("R3", "level 1 last", 64'(grant), 64'h10);
        req_lines = '0;
        pulse_done();
        tick();
    endtask

    task automatic t_tie();
        stream_prio[4*2 +: 2] = 2'd2;
        stream_prio[6*2 +: 2] = 2'd2;
        stream_prio[7*2 +: 2] = 2'd2;
        stream_en[7] = 1'b1;
        req_lines[7*NC] = 1'b1;
        req_lines[6*NC] = 1'b1;
        req_lines[4*NC] = 1'b1;
        tick();
        check("R4", "lowest index of three", 64'(grant), 64'h10);
        req_lines[4*NC] = 1'b0;
        pulse_done();
        tick();
        check("R4", "lowest of remaining", 64'(grant), 64'h40);
        req_lines = '0;
        pulse_done();
        tick();
        stream_en = '0;
        stream_en[1:0] = 2'b11;
        req_lines[1*NC] = 1'b1;
        req_lines[0*NC] = 1'b1;
        tick();
        check("R4", "tie at level 0", 64'(grant), 64'h01);
        req_lines = '0;
        pulse_done();
        stream_en = '0;
        tick();
    endtask

    task automatic t_hold();
        stream_prio[4*2 +: 2] = 2'd1;
        stream_en[4] = 1'b1;
        req_lines[4*NC] = 1'b1;
        tick();
        check("R6", "grant taken", 64'(grant), 64'h10);
        stream_prio[5*2 +: 2] = 2'd3;
        stream_en[5] = 1'b1;
        req_lines[5*NC] = 1'b1;
        stream_en[4] = 1'b0;
        req_lines[4*NC] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6", "grant held", 64'(grant), 64'h10);
        end
        pulse_done();
        check("R7", "ack for held stream", ack, 64'h1 << (4*NC));
        tick();
        check("R8", "rearbitrated winner", 64'(grant), 64'h20);
        req_lines = '0;
        pulse_done();
        stream_en = '0;
        tick();
    endtask

    task automatic t_idle_done();
        pulse_done();
        check("R7", "done while idle no ack", ack, 64'h0);
        check("R7", "done while idle no grant", 64'(grant), 64'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        req_lines = '0; stream_en = '0; sel_wr = '0; sel_data = '0;
        stream_prio = '0; bus_done = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_lock();
        t_prio();
        t_tie();
        t_hold();
        t_idle_done();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule